// File: doc/BRIEF.md
# Multi-channel audio zero-run detector

This block watches three parallel DAC sample streams. Each stream has its own valid strobe and a signed sample word. For every channel it counts an unbroken run of zero-valued samples. Once that run reaches a set length, it raises a flag for that channel. The intended use is to let downstream logic, or an external mute circuit, silence outputs that are carrying nothing but digital silence.

A 2-bit selector picks what drives a single mute indicator output. The indicator can follow one channel's flag, or it can follow the condition that every channel is silent at once. An enable input lets each channel's flag also drive that channel's own mute request, so the channel mutes itself when it goes quiet.

Top module: `audio_zero_watch`

## Requirements
- R1: A channel's flag `zero_flag[c]` goes to 1 on the clock edge that accepts the 1024th consecutive zero sample on that channel. It stays 0 after only 1023 such samples.
- R2: A valid sample that is not zero on channel c clears that channel's run. `zero_flag[c]` is 0 after that same edge. The other channels are not affected.
- R3: The run count saturates at the threshold. Any number of further zero samples keeps the flag at 1, with no wrap.
- R4: A channel's run advances or clears only on cycles where `smp_valid[c]` is 1. Sample data on cycles where the strobe is low is ignored, and the run already counted is kept.
- R5: When `flag_sel` = 2'b00, `mute_ind` is 1 only when all three channel flags are 1. A 1 on `mute_ind` means zero is detected.
- R6: `flag_sel` = 2'b01, 2'b10 and 2'b11 route the flag of channel 1 (`zero_flag[0]`), channel 2 (`zero_flag[1]`) and channel 3 (`zero_flag[2]`) to `mute_ind`.
- R7: `mute_req[c]` equals `zero_flag[c]` when `auto_mute_en` is 1. All mute requests are 0 when it is 0.
- R8: While `rst_n` is 0 at a rising clock edge, all run counts and flags are cleared. Zero samples arriving during reset do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 3 | Per-channel sample strobe; bit c belongs to channel c+1 |
| smp_data | input | 72 | Packed samples; channel c+1 occupies bits [c*24 +: 24] |
| flag_sel | input | 2 | Indicator source: 00 all channels, 01/10/11 channel 1/2/3 |
| auto_mute_en | input | 1 | Lets each flag drive its channel's mute request |
| zero_flag | output | 3 | Per-channel zero-run flags |
| mute_ind | output | 1 | Selected zero indication (1 = zero detected) |
| mute_req | output | 3 | Per-channel automatic mute requests |

## Verification
The run counters are driven with three kinds of input:
- All-zero runs of 1023, 1024 and 3000 samples. These separate an off-by-one threshold from a correct one, and a saturating counter from one that wraps.
- Mixed patterns where some channels carry zeros and others carry small or most-negative nonzero values. Each selector value is applied to these, which shows whether the AND-of-all mode and each single-channel route pick the right flag.
- Runs broken by a single nonzero sample, and runs interrupted by long stretches of nonzero data with the strobe low. These distinguish "clear on nonzero" from "ignore without strobe", per channel.

// File: rtl/azw_pkg.sv
// Package: shared types for the audio zero-run detector.
// Assumes a 2-bit selector that can address at most three channels.
package azw_pkg;

    // Encodings of the indicator-source selector
    typedef enum logic [1:0] {
        SEL_ALL = 2'b00,
        SEL_CH1 = 2'b01,
        SEL_CH2 = 2'b10,
        SEL_CH3 = 2'b11
    } flag_sel_e;

    // Highest channel count the selector encoding can address
    localparam int unsigned MAX_SEL_CH = 3;

endpackage

// File: rtl/zero_run_counter.sv
// Module: zero_run_counter
// Counts consecutive zero samples on one stream and flags a run of RUN_LEN.
// Assumes: data is only meaningful while valid is high; synchronous
// active-low reset; the count saturates at RUN_LEN.
module zero_run_counter #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] data,
    output logic                zero_flag
);

    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_cnt;
    logic             is_zero;
    logic             at_max;

    // Purpose: classify the current sample and the saturation state
    always_comb begin
        is_zero = (data == '0);
        at_max  = (run_cnt == CNT_MAX);
    end

    // Purpose: advance, hold or clear the run count on strobed samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (valid) begin
            if (!is_zero) begin
                run_cnt <= '0;
            end else if (!at_max) begin
                run_cnt <= run_cnt + CNT_ONE;
            end
        end
    end

    // Purpose: the flag is the saturated state of the counter
    assign zero_flag = at_max;

    // R3: count never passes the threshold
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_MAX);

    // R3: a set flag survives further zero samples
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag && valid && is_zero) |=> zero_flag);

    // R2: a strobed nonzero sample drops the flag at that edge
    p_clear_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_zero) |=> !zero_flag);

    // R4: without a strobe the count is frozen
    p_hold_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(run_cnt));

    // R1: the flag can only rise on a strobed zero sample
    p_rise_on_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> $past(valid && is_zero));

    // R8: reset leaves the count empty
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (run_cnt == '0));

endmodule

// File: rtl/mute_router.sv
// Module: mute_router
// Selects the flag (or AND of all flags) for the mute indicator and gates
// per-channel mute requests with the auto-mute enable.
// Assumes: NUM_CH <= 3; selector codes above NUM_CH give a 0 indicator.
module mute_router
    import azw_pkg::*;
#(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] flags,
    input  logic [1:0]        sel,
    input  logic              auto_en,
    output logic              mute_ind,
    output logic [NUM_CH-1:0] mute_req
);

    flag_sel_e   sel_e;
    logic        all_zero;
    logic [1:0]  ch_idx;

    // Purpose: decode the selector and pick the indicator source
    always_comb begin
        sel_e    = flag_sel_e'(sel);
        all_zero = &flags;
        ch_idx   = sel - 2'd1;
        mute_ind = 1'b0;
        if (sel_e == SEL_ALL) begin
            mute_ind = all_zero;
        end else if (int'(ch_idx) < int'(NUM_CH)) begin
            mute_ind = flags[ch_idx];
        end
    end

    // Purpose: per-channel automatic mute gating
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_req
            assign mute_req[c] = flags[c] & auto_en;
        end
    endgenerate

    // R5: all-channel mode never indicates while any channel is live
    p_all_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && !(&flags)) |-> !mute_ind);

    // R6: single-channel mode indicates only when some flag is set
    p_single_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != 2'b00 && flags == '0) |-> !mute_ind);

    // R7: no request without enable
    p_req_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> (mute_req == '0));

    // R7: a request always has a matching flag
    p_req_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req & ~flags) == '0);

endmodule

// File: rtl/audio_zero_watch.sv
// Module: audio_zero_watch (top)
// One zero-run counter per channel plus the mute indicator router.
// Assumes: channel c+1 sample at smp_data[c*SAMPLE_W +: SAMPLE_W];
// synchronous active-low reset.
module audio_zero_watch
    import azw_pkg::*;
#(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned RUN_LEN  = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic [1:0]                 flag_sel,
    input  logic                       auto_mute_en,
    output logic [NUM_CH-1:0]          zero_flag,
    output logic                       mute_ind,
    output logic [NUM_CH-1:0]          mute_req
);

    // Purpose: instantiate one run counter per channel
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            zero_run_counter #(
                .SAMPLE_W (SAMPLE_W),
                .RUN_LEN  (RUN_LEN)
            ) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .valid     (smp_valid[c]),
                .data      (smp_data[c*SAMPLE_W +: SAMPLE_W]),
                .zero_flag (zero_flag[c])
            );
        end
    endgenerate

    // Purpose: indicator selection and auto-mute gating
    mute_router #(
        .NUM_CH (NUM_CH)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags    (zero_flag),
        .sel      (flag_sel),
        .auto_en  (auto_mute_en),
        .mute_ind (mute_ind),
        .mute_req (mute_req)
    );

    // Parameter sanity: the selector cannot address more than three channels
    initial begin
        p_ch_limit: assert (NUM_CH >= 1 && NUM_CH <= MAX_SEL_CH);
    end

endmodule

// File: tb/audio_zero_watch_test.sv
`timescale 1ns/1ps
module audio_zero_watch_test;

    localparam int NCH = 3;
    localparam int SW  = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    smp_valid = '0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic [1:0]        flag_sel = 2'b00;
    logic              auto_mute_en = 1'b0;
    logic [NCH-1:0]    zero_flag;
    logic              mute_ind;
    logic [NCH-1:0]    mute_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    audio_zero_watch uut (
        .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid),
        .smp_data (smp_data), .flag_sel (flag_sel),
        .auto_mute_en (auto_mute_en), .zero_flag (zero_flag),
        .mute_ind (mute_ind), .mute_req (mute_req)
    );

    // Vector: mask[24:22] len[21:10] sel[9:8] am[7] flags[6:4] ind[3] req[2:0]
    localparam int NV = 8;
    localparam logic [24:0] VEC [NV] = '{
        {3'b111, 12'd1024, 2'b00, 1'b0, 3'b111, 1'b1, 3'b000},
        {3'b111, 12'd1023, 2'b00, 1'b0, 3'b000, 1'b0, 3'b000},
        {3'b011, 12'd1024, 2'b00, 1'b0, 3'b011, 1'b0, 3'b000},
        {3'b011, 12'd1024, 2'b01, 1'b0, 3'b011, 1'b1, 3'b000},
        {3'b011, 12'd1024, 2'b10, 1'b1, 3'b011, 1'b1, 3'b011},
        {3'b011, 12'd1024, 2'b11, 1'b1, 3'b011, 1'b0, 3'b011},
        {3'b100, 12'd1024, 2'b11, 1'b1, 3'b100, 1'b1, 3'b100},
        {3'b101, 12'd1030, 2'b00, 1'b1, 3'b101, 1'b0, 3'b101}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle: vmask strobes, zmask channels zero, others nonzero
    task automatic drive(input logic [2:0] vmask, input logic [2:0] zmask);
        @(negedge clk);
        smp_valid = vmask;
        for (int c = 0; c < NCH; c++) begin
            smp_data[c*SW +: SW] = zmask[c] ? '0 :
                                   ((c == 1) ? 24'h800000 : 24'h000001 + c);
        end
    endtask

    task automatic feed(input logic [2:0] vmask, input logic [2:0] zmask,
                        input int n);
        for (int i = 0; i < n; i++) drive(vmask, zmask);
        @(negedge clk);
        smp_valid = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = '1;
        smp_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        smp_valid = '0;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state with zero samples strobed during reset
        @(negedge clk);
        smp_valid = '1;
        repeat (3) @(negedge clk);
        check("R8 flags in reset", 32'(zero_flag), 32'h0);
        check("R8 mute_req in reset", 32'(mute_req), 32'h0);
        rst_n = 1'b1;
        smp_valid = '0;

        // Table walk: R1 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            do_reset();
            flag_sel     = VEC[v][9:8];
            auto_mute_en = VEC[v][7];
            feed(3'b111, VEC[v][24:22], int'(VEC[v][21:10]));
            check($sformatf("R1 vec%0d flags", v), 32'(zero_flag), 32'(VEC[v][6:4]));
            check($sformatf("R5/R6 vec%0d mute_ind", v), 32'(mute_ind), 32'(VEC[v][3]));
            check($sformatf("R7 vec%0d mute_req", v), 32'(mute_req), 32'(VEC[v][2:0]));
        end

        // R2: single nonzero on channel 2 clears only it
        do_reset();
        flag_sel = 2'b00; auto_mute_en = 1'b1;
        feed(3'b111, 3'b111, 1024);
        check("R2 pre flags", 32'(zero_flag), 32'h7);
        feed(3'b111, 3'b101, 1);
        check("R2 nonzero clears ch2", 32'(zero_flag), 32'h5);
        check("R2 mute_ind drops", 32'(mute_ind), 32'h0);

        // R3: long run saturates, then a break restarts from zero
        do_reset();
        feed(3'b111, 3'b111, 3000);
        check("R3 saturated flags", 32'(zero_flag), 32'h7);
        feed(3'b111, 3'b110, 1);
        check("R3 break ch1", 32'(zero_flag), 32'h6);
        feed(3'b111, 3'b111, 1023);
        check("R1 restart 1023 short", 32'(zero_flag), 32'h6);
        feed(3'b001, 3'b111, 1);
        check("R1 restart reaches 1024", 32'(zero_flag), 32'h7);

        // R4: unstrobed nonzero data is ignored, run is kept
        do_reset();
        feed(3'b111, 3'b111, 1023);
        feed(3'b000, 3'b000, 50);
        check("R4 no flag yet", 32'(zero_flag), 32'h0);
        feed(3'b001, 3'b111, 1);
        check("R4 only strobed ch1 completes", 32'(zero_flag), 32'h1);
        feed(3'b110, 3'b111, 1);
        check("R4 all complete", 32'(zero_flag), 32'h7);

        // R8: reset mid-run clears set flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R8 reset clears flags", 32'(zero_flag), 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule